// File: doc/BRIEF.md
# Interrupt Source Vector Register

This block is a read-only status register for a serial bus controller. It encodes the highest-priority pending interrupt condition as a 4-bit index. The index sits in bits 5..2, so the byte that software reads is already a jump-table offset in steps of four. An index of zero means that nothing is pending. A handler can add the value it reads to a table base and branch there. Software then needs no copy of the controller's state machine.

Reading the register also generates the clear pulses for the condition flags, which live outside the block. Error, arbitration, wake-up and end-of-frame conditions clear on the vector read alone. The receive-data and receive-in-frame-response conditions clear only when a later read of the data register follows the vector read. The transmit-empty condition clears in one of two ways: when a later write to the data register follows the vector read, or at once when software sets end-of-data.

A small record of the last vector read is kept inside the block. It stores whether that read reported a data-register condition, and which one. The next data-register access uses up this record, whether or not it completes a clear.

Top module: `isr_vector_reg`

## Requirements
- R1: `rd_data` bits 7, 6, 1 and 0 are always 0. Bits 5..2 carry the index. Index k (1..8) stands for `evt_pend[k-1]`, so the value read is 4*k. The bits of `evt_pend` are: 0 bus fault, 1 lost arbitration, 2 invalid symbol, 3 wake-up, 4 received in-frame-response data, 5 received data full, 6 transmit data empty, 7 end of frame.
- R2: While reset is active, `rd_data` is 0x00. The record of a data-register condition is also discarded, so after reset a data-register access clears nothing.
- R3: The index names the lowest-numbered bit of `evt_pend` that is set. It is 0 when no bit is set. A change on `evt_pend` shows in `rd_data` after the next rising clock edge.
- R4: A `vec_rd` pulse while the index names bit 0, 1, 2, 3 or 7 drives `evt_clr` high for that bit only, in the same cycle. A `vec_rd` pulse while the index is 0 clears nothing.
- R5: A `vec_rd` pulse while the index names bit 4 or 5 clears nothing. The first `dr_rd` pulse after it drives `evt_clr` for that bit, in the cycle of the `dr_rd` pulse.
- R6: A `vec_rd` pulse while the index names bit 6 clears nothing. A `dr_wr` pulse that follows it drives `evt_clr[6]`, in the cycle of the `dr_wr` pulse.
- R7: An `eod_set` pulse drives `evt_clr[6]` in the same cycle, whether or not a vector read came before it.
- R8: A data-register access produces no clear in these cases: no vector read came before it; the access is of the wrong kind (a write after a receive condition was reported); or the record was already used by an earlier access or by `eod_set`.
- R9: A source is cleared by a pulse on `evt_clr`. On the rising edge that ends that cycle, the index moves to the next pending source and does not wait for `evt_pend` to fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pend | input | 8 | Pending condition flags, bit 0 has the highest priority |
| vec_rd | input | 1 | One-cycle strobe: CPU read of this register |
| dr_rd | input | 1 | One-cycle strobe: CPU read of the data register |
| dr_wr | input | 1 | One-cycle strobe: CPU write of the data register |
| eod_set | input | 1 | One-cycle strobe: software sets end-of-data |
| rd_data | output | 8 | Register value: index in bits 5..2, all other bits zero |
| evt_clr | output | 8 | Clear pulses back to the condition flags, one per bit of `evt_pend` |

## Verification
The clear pulses come from combinational logic, so `evt_clr` is due in the same cycle as the strobe that causes it. The index is registered, so `rd_data` shows a new pending set, or the effect of a clear, one rising edge later. The bench applies each cycle's flags and strobes just after a falling edge and samples both outputs 1 ns later. Its flag model drops a cleared bit only in the following cycle, which matches the way the external flags behave.

// File: rtl/isv_pkg.sv
package isv_pkg;

  // Kind of data-register condition recorded by the last vector read
  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_RX   = 2'd1,
    ARM_TX   = 2'd2
  } arm_kind_e;

  localparam int IDX_W  = 4;
  localparam int DATA_W = 8;
  localparam int IDX_LSB = 2;

  // Turn an index into the byte software reads: a multiple of four
  function automatic logic [DATA_W-1:0] isv_offset(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    v = '0;
    v[IDX_LSB +: IDX_W] = idx;
    return v;
  endfunction

endpackage

// File: rtl/isv_prio_enc.sv
module isv_prio_enc #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 4
) (
  input  logic [NSRC-1:0]  req,
  output logic [IDX_W-1:0] idx
);

  // Lowest-numbered request wins; index is bit number plus one
  always_comb begin
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (req[k]) idx = IDX_W'(k + 1);
    end
  end

endmodule

// File: rtl/isv_clr_seq.sv
module isv_clr_seq
  import isv_pkg::*;
#(
  parameter int              NSRC    = 8,
  parameter int              IDX_W   = 4,
  parameter logic [NSRC-1:0] RX_MASK = 8'h30,
  parameter logic [NSRC-1:0] TX_MASK = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             vec_rd,
  input  logic             dr_rd,
  input  logic             dr_wr,
  input  logic             eod_set,
  output logic [NSRC-1:0]  evt_clr,
  output logic [NSRC-1:0]  rd_clear,
  output logic [NSRC-1:0]  rx_done,
  output logic [NSRC-1:0]  tx_done,
  output logic [NSRC-1:0]  eod_clear,
  output arm_kind_e        arm_kind
);

  localparam logic [NSRC-1:0] DATA_MASK = RX_MASK | TX_MASK;

  logic [NSRC-1:0] sel;
  arm_kind_e       arm_q, arm_d;
  logic [NSRC-1:0] arm_sel_q, arm_sel_d;

  // One-hot decode of the reported index
  for (genvar k = 0; k < NSRC; k++) begin : g_sel
    assign sel[k] = (cur_idx == IDX_W'(k + 1));
  end

  assign rd_clear  = vec_rd ? (sel & ~DATA_MASK) : '0;
  assign rx_done   = (dr_rd && arm_q == ARM_RX) ? arm_sel_q : '0;
  assign tx_done   = (dr_wr && arm_q == ARM_TX) ? arm_sel_q : '0;
  assign eod_clear = eod_set ? TX_MASK : '0;
  assign evt_clr   = rd_clear | rx_done | tx_done | eod_clear;
  assign arm_kind  = arm_q;

  always_comb begin
    arm_d     = arm_q;
    arm_sel_d = arm_sel_q;
    if (vec_rd) begin
      arm_sel_d = sel;
      if (|(sel & RX_MASK))      arm_d = ARM_RX;
      else if (|(sel & TX_MASK)) arm_d = ARM_TX;
      else                       arm_d = ARM_NONE;
    end else if (dr_rd || dr_wr) begin
      arm_d = ARM_NONE;
    end else if (eod_set && arm_q == ARM_TX) begin
      arm_d = ARM_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= ARM_NONE;
      arm_sel_q <= '0;
    end else begin
      arm_q     <= arm_d;
      arm_sel_q <= arm_sel_d;
    end
  end

endmodule

// File: rtl/isr_vector_reg.sv
module isr_vector_reg
  import isv_pkg::*;
#(
  parameter int              NSRC    = 8,
  parameter logic [NSRC-1:0] RX_MASK = 8'h30,
  parameter logic [NSRC-1:0] TX_MASK = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_pend,
  input  logic              vec_rd,
  input  logic              dr_rd,
  input  logic              dr_wr,
  input  logic              eod_set,
  output logic [DATA_W-1:0] rd_data,
  output logic [NSRC-1:0]   evt_clr
);

  logic [IDX_W-1:0] vec_q;
  logic [IDX_W-1:0] next_idx;
  logic [NSRC-1:0]  live_pend;
  logic [NSRC-1:0]  rd_clear, rx_done, tx_done, eod_clear;
  arm_kind_e        arm_kind;

  // Sources cleared this cycle no longer compete at the next edge
  assign live_pend = evt_pend & ~evt_clr;

  isv_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
    .req (live_pend),
    .idx (next_idx)
  );

  isv_clr_seq #(
    .NSRC(NSRC), .IDX_W(IDX_W), .RX_MASK(RX_MASK), .TX_MASK(TX_MASK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_idx   (vec_q),
    .vec_rd    (vec_rd),
    .dr_rd     (dr_rd),
    .dr_wr     (dr_wr),
    .eod_set   (eod_set),
    .evt_clr   (evt_clr),
    .rd_clear  (rd_clear),
    .rx_done   (rx_done),
    .tx_done   (tx_done),
    .eod_clear (eod_clear),
    .arm_kind  (arm_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= next_idx;
  end

  assign rd_data = isv_offset(vec_q);

endmodule

// File: rtl/isv_chk.sv
module isv_chk
  import isv_pkg::*;
#(
  parameter int              NSRC    = 8,
  parameter logic [NSRC-1:0] RX_MASK = 8'h30,
  parameter logic [NSRC-1:0] TX_MASK = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_pend,
  input logic              vec_rd,
  input logic              dr_rd,
  input logic              dr_wr,
  input logic              eod_set,
  input logic [DATA_W-1:0] rd_data,
  input logic [NSRC-1:0]   evt_clr,
  input arm_kind_e         arm_kind
);

  logic [IDX_W-1:0] shown;
  logic [NSRC-1:0]  shown_sel;
  assign shown     = rd_data[IDX_LSB +: IDX_W];
  assign shown_sel = (shown == '0) ? '0
                   : ({{(NSRC-1){1'b0}}, 1'b1} << (shown - 4'd1));

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00);

  p_reset_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  p_idle_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pend == '0) |=> rd_data == '0);

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && shown != '0 && (shown_sel & (RX_MASK | TX_MASK)) == '0)
      |-> (evt_clr & shown_sel) == shown_sel);

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !dr_rd && (shown_sel & RX_MASK) != '0)
      |-> (evt_clr & shown_sel) == '0);

  p_tx_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && (shown_sel & TX_MASK) != '0) ##1 dr_wr
      |-> (evt_clr & TX_MASK) != '0);

  p_eod_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eod_set |-> (evt_clr & TX_MASK) == TX_MASK);

  p_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_kind == ARM_NONE && !eod_set) |-> (evt_clr & (RX_MASK | TX_MASK)) == '0);

endmodule

bind isr_vector_reg isv_chk #(
  .NSRC(NSRC), .RX_MASK(RX_MASK), .TX_MASK(TX_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_pend (evt_pend),
  .vec_rd   (vec_rd),
  .dr_rd    (dr_rd),
  .dr_wr    (dr_wr),
  .eod_set  (eod_set),
  .rd_data  (rd_data),
  .evt_clr  (evt_clr),
  .arm_kind (arm_kind)
);

// File: tb/sim_isr_vector_reg.sv
module sim_isr_vector_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_pend = '0;
  logic       vec_rd = 1'b0, dr_rd = 1'b0, dr_wr = 1'b0, eod_set = 1'b0;
  logic [7:0] rd_data, evt_clr;

  always #2 clk = ~clk;  // 250 MHz

  isr_vector_reg u0 (
    .clk(clk), .rst_n(rst_n), .evt_pend(evt_pend), .vec_rd(vec_rd),
    .dr_rd(dr_rd), .dr_wr(dr_wr), .eod_set(eod_set),
    .rd_data(rd_data), .evt_clr(evt_clr)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] pend = '0, clr_prev = '0, got_rd, got_clr;

  // Row: {set mask, vr, drd, dwr, eod, expected rd_data, expected evt_clr}
  localparam int ROWS = 25;
  localparam logic [27:0] VEC [ROWS] = '{
    {8'h00, 4'b1000, 8'h00, 8'h00},  // 0  R2 R4: idle, read clears nothing
    {8'h80, 4'b0000, 8'h00, 8'h00},  // 1  R3: not visible yet
    {8'h00, 4'b1000, 8'h20, 8'h80},  // 2  R1 R4: end of frame cleared by read
    {8'h30, 4'b0000, 8'h00, 8'h00},  // 3
    {8'h00, 4'b1000, 8'h14, 8'h00},  // 4  R3 R5: rx IFR read, no clear
    {8'h00, 4'b0100, 8'h14, 8'h10},  // 5  R5: data read clears
    {8'h00, 4'b0100, 8'h18, 8'h00},  // 6  R9 R8: next source, unarmed read
    {8'h00, 4'b1000, 8'h18, 8'h00},  // 7  R5: arm rx full
    {8'h00, 4'b0010, 8'h18, 8'h00},  // 8  R8: wrong access kind
    {8'h00, 4'b0100, 8'h18, 8'h00},  // 9  R8: record already used
    {8'h00, 4'b1000, 8'h18, 8'h00},  // 10
    {8'h00, 4'b0100, 8'h18, 8'h20},  // 11 R5
    {8'h40, 4'b0000, 8'h00, 8'h00},  // 12 R9
    {8'h00, 4'b1000, 8'h1C, 8'h00},  // 13 R6: tx empty read, no clear
    {8'h00, 4'b0010, 8'h1C, 8'h40},  // 14 R6: data write clears
    {8'h4B, 4'b0000, 8'h00, 8'h00},  // 15
    {8'h00, 4'b1000, 8'h04, 8'h01},  // 16 R3 R4: bus fault first
    {8'h00, 4'b1000, 8'h08, 8'h02},  // 17 R9 R4
    {8'h00, 4'b0001, 8'h10, 8'h40},  // 18 R7: end-of-data without read
    {8'h00, 4'b1000, 8'h10, 8'h08},  // 19 R4
    {8'h40, 4'b0000, 8'h00, 8'h00},  // 20
    {8'h00, 4'b1000, 8'h1C, 8'h00},  // 21 R6: arm tx
    {8'h00, 4'b0001, 8'h1C, 8'h40},  // 22 R7: end-of-data uses the record
    {8'h40, 4'b0010, 8'h00, 8'h00},  // 23 R8: write finds no record
    {8'h00, 4'b0011, 8'h1C, 8'h40}   // 24 R7
  };

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one
  task automatic step(input logic [7:0] set, input logic [3:0] strb);
    pend = (pend & ~clr_prev) | set;
    evt_pend = pend;
    {vec_rd, dr_rd, dr_wr, eod_set} = strb;
    #1;
    got_rd  = rd_data;
    got_clr = evt_clr;
    @(posedge clk);
    @(negedge clk);
    clr_prev = got_clr;
    {vec_rd, dr_rd, dr_wr, eod_set} = 4'b0000;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    #1;
    check8("R2 rd_data in reset", rd_data, 8'h00);
    check8("R2 evt_clr in reset", evt_clr, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < ROWS; i++) begin
      step(VEC[i][27:20], VEC[i][19:16]);
      check8($sformatf("R1 R3 R9 rd_data row %0d", i), got_rd, VEC[i][15:8]);
      check8($sformatf("R4 R5 R6 R7 R8 evt_clr row %0d", i), got_clr, VEC[i][7:0]);
    end

    // Drain: pend is 0x40, cleared in row 24
    step(8'h00, 4'b0000);
    // Arm a receive record, then reset must discard it (R2, R8)
    step(8'h20, 4'b0000);
    step(8'h00, 4'b1000);
    check8("R5 armed read no clear", got_clr, 8'h00);
    rst_n = 1'b0;
    step(8'h00, 4'b0000);
    check8("R2 rd_data during reset", got_rd, 8'h00);
    rst_n = 1'b1;
    step(8'h00, 4'b0100);
    check8("R2 rd_data after reset", got_rd, 8'h00);
    check8("R2 R8 record dropped by reset", got_clr, 8'h00);
    step(8'h00, 4'b0000);
    check8("R3 pending source reappears", got_rd, 8'h18);

    finish_run();
  end

endmodule